// File: doc/BRIEF.md
# Pattern Compare and Bit-Manipulation Unit

This unit evaluates one of eleven compare or single-operand bit operations on two 32-bit operands in each accepted cycle. The compare group reports the position of the first equal byte between the two operands, counting from the most significant byte. It also reports whether the operands are equal or not equal. The single-operand group counts leading zeros, swaps bytes or halfwords, sign-extends a byte or a halfword, and shifts right by one bit, with the vacated top bit taken from the sign, from zero or from the incoming carry.

A caller presents `valid_i`, an operation code on `op_i`, the operands and the current carry flag. One clock later the registered result, the new carry and `valid_o` appear. Only the three shift operations produce a new carry. Every other code passes the incoming carry through unchanged.

Top module: `pcbm_unit`

## Requirements
- R1: After reset, `valid_o` is 0, `result_o` is 0 and `carry_o` is 0.
- R2: An operation accepted with `valid_i`=1 at a rising edge presents its result, new carry and `valid_o`=1 after that edge. A cycle with `valid_i`=0 gives `valid_o`=0 on the next cycle and leaves `result_o` and `carry_o` unchanged.
- R3: Code 0 (byte find) returns 1 when bits 31:24 of the two operands match, 2 for bits 23:16, 3 for bits 15:8, 4 for bits 7:0 and 0 when no byte matches. The most significant matching byte wins.
- R4: Code 1 returns 1 when `ra_i` equals `rb_i` and 0 otherwise. Code 2 returns the inverse.
- R5: Code 3 returns the number of zero bits above the highest set bit of `ra_i`. It returns 32 for an all-zero operand.
- R6: Code 4 reverses the order of the four bytes of `ra_i`. Code 5 exchanges its upper and lower 16-bit halves.
- R7: Code 6 copies bit 7 of `ra_i` into bits 31:8 above its low byte. Code 7 copies bit 15 into bits 31:16 above its low half.
- R8: Codes 8, 9 and 10 shift `ra_i` right by one. Code 8 fills bit 31 with the old bit 31, code 9 fills it with `carry_i`, and code 10 fills it with 0.
- R9: For codes 8, 9 and 10 the new carry is bit 0 of `ra_i`.
- R10: For every code other than 8, 9 and 10, the new carry equals `carry_i`. Codes 11 to 15 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| ra_i | input | 32 | First operand |
| rb_i | input | 32 | Second operand (byte find and equality only) |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered new carry flag |

## Verification
Every result, including the new carry, is due exactly one rising edge after the edge that accepts the operation. `valid_o` marks the cycle in which each result appears.

The driver applies stimulus on falling edges and pushes the expected result and carry into a queue. The monitor samples on falling edges: whenever `valid_o` is high it pops one item, so each compare falls half a cycle after the output register updates. Idle cycles check that the outputs hold and that `valid_o` drops on the following cycle.

// File: rtl/pcbm_pkg.sv
package pcbm_pkg;
    typedef enum logic [3:0] {
        OP_BFIND  = 4'd0,
        OP_EQ     = 4'd1,
        OP_NE     = 4'd2,
        OP_CLZ    = 4'd3,
        OP_BSWAP  = 4'd4,
        OP_HSWAP  = 4'd5,
        OP_SEXT8  = 4'd6,
        OP_SEXT16 = 4'd7,
        OP_SHRA   = 4'd8,
        OP_SHRC   = 4'd9,
        OP_SHRL   = 4'd10
    } op_e;

    function automatic logic is_shift(input logic [3:0] op);
        return (op == OP_SHRA) || (op == OP_SHRC) || (op == OP_SHRL);
    endfunction
endpackage

// File: rtl/pcbm_cmp.sv
module pcbm_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    output logic [$clog2(W/8+1)-1:0] find_o,
    output logic                 eq_o
);
    localparam int NB = W / 8;
    localparam int IW = $clog2(NB + 1);

    logic [NB-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_byte
            assign hit[g] = (a_i[g*8 +: 8] == b_i[g*8 +: 8]);
        end
    endgenerate

    // later iterations win, so scanning upward gives the top byte priority
    always_comb begin
        find_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (hit[i]) find_o = IW'(NB - i);
        end
    end

    assign eq_o = &hit;
endmodule

// File: rtl/pcbm_clz.sv
module pcbm_clz #(
    parameter int W = 32
) (
    input  logic [W-1:0]            a_i,
    output logic [$clog2(W+1)-1:0]  cnt_o
);
    localparam int CW = $clog2(W + 1);

    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/pcbm_perm.sv
module pcbm_perm #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    output logic [W-1:0] res_o
);
    import pcbm_pkg::*;

    localparam int NB = W / 8;
    localparam int HW = W / 2;

    logic [W-1:0] bswap;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_swap
            assign bswap[g*8 +: 8] = a_i[(NB-1-g)*8 +: 8];
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            OP_BSWAP:  res_o = bswap;
            OP_HSWAP:  res_o = {a_i[HW-1:0], a_i[W-1:HW]};
            OP_SEXT8:  res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
            OP_SEXT16: res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
            OP_SHRA:   res_o = {a_i[W-1], a_i[W-1:1]};
            OP_SHRC:   res_o = {c_i, a_i[W-1:1]};
            OP_SHRL:   res_o = {1'b0, a_i[W-1:1]};
            default:   res_o = '0;
        endcase
    end
endmodule

// File: rtl/pcbm_unit.sv
module pcbm_unit #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] ra_i,
    input  logic [W-1:0] rb_i,
    input  logic         carry_i,
    output logic         valid_o,
    output logic [W-1:0] result_o,
    output logic         carry_o
);
    import pcbm_pkg::*;

    localparam int FW = $clog2(W/8 + 1);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         cry;
    } state_t;

    state_t st_d, st_q;

    logic [FW-1:0] find;
    logic          eq;
    logic [CW-1:0] lz;
    logic [W-1:0]  perm;

    pcbm_cmp #(.W(W)) u_cmp (
        .a_i    (ra_i),
        .b_i    (rb_i),
        .find_o (find),
        .eq_o   (eq)
    );

    pcbm_clz #(.W(W)) u_clz (
        .a_i   (ra_i),
        .cnt_o (lz)
    );

    pcbm_perm #(.W(W)) u_perm (
        .op_i  (op_i),
        .a_i   (ra_i),
        .c_i   (carry_i),
        .res_o (perm)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            unique case (op_i)
                OP_BFIND: st_d.res = W'(find);
                OP_EQ:    st_d.res = W'(eq);
                OP_NE:    st_d.res = W'(!eq);
                OP_CLZ:   st_d.res = W'(lz);
                default:  st_d.res = perm;
            endcase
            st_d.cry = is_shift(op_i) ? ra_i[0] : carry_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o  = st_q.vld;
    assign result_o = st_q.res;
    assign carry_o  = st_q.cry;
endmodule

// File: rtl/pcbm_unit_chk.sv
module pcbm_unit_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         valid_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] ra_i,
    input logic [W-1:0] rb_i,
    input logic         carry_i,
    input logic         valid_o,
    input logic [W-1:0] result_o,
    input logic         carry_o
);
    import pcbm_pkg::*;

    // R2
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!valid_o && $stable(result_o) && $stable(carry_o)));

    // R9
    shift_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && is_shift(op_i)) |=> (carry_o == $past(ra_i[0])));

    // R10
    carry_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !is_shift(op_i)) |=> (carry_o == $past(carry_i)));

    // R3
    find_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_BFIND) |=> (result_o <= W'(W/8)));

    // R4
    eq_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_EQ) |=> (result_o == W'($past(ra_i) == $past(rb_i))));

    // R5
    clz_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_CLZ && ra_i == '0) |=> (result_o == W'(W)));
endmodule

bind pcbm_unit pcbm_unit_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .ra_i     (ra_i),
    .rb_i     (rb_i),
    .carry_i  (carry_i),
    .valid_o  (valid_o),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/pcbm_unit_tb.sv
module pcbm_unit_tb;
    localparam int W = 32;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   op_i = '0;
    logic [W-1:0] ra_i = '0;
    logic [W-1:0] rb_i = '0;
    logic         carry_i = 1'b0;
    logic         valid_o;
    logic [W-1:0] result_o;
    logic         carry_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] res;
        logic        cry;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk_i = ~clk_i;

    pcbm_unit #(.W(W)) u_dut (.*);

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0:        return "R3";
            4'd1, 4'd2:  return "R4";
            4'd3:        return "R5";
            4'd4, 4'd5:  return "R6";
            4'd6, 4'd7:  return "R7";
            4'd8, 4'd9, 4'd10: return "R8";
            default:     return "R10";
        endcase
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic c,
                                  output logic [31:0] r, output logic co);
        r  = 32'd0;
        co = c;
        case (op)
            4'd0: begin
                for (int k = 4; k >= 1; k--)
                    if (a[32-8*k +: 8] == b[32-8*k +: 8]) r = 32'(k);
            end
            4'd1: r = (a == b) ? 32'd1 : 32'd0;
            4'd2: r = (a != b) ? 32'd1 : 32'd0;
            4'd3: begin
                int n = 0;
                while (n < 32 && a[31-n] == 1'b0) n++;
                r = 32'(n);
            end
            4'd4: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
            4'd5: r = {a[15:0], a[31:16]};
            4'd6: r = a[7]  ? (a | 32'hFFFF_FF00) : (a & 32'h0000_00FF);
            4'd7: r = a[15] ? (a | 32'hFFFF_0000) : (a & 32'h0000_FFFF);
            4'd8:  begin r = (a >> 1) | (a & 32'h8000_0000); co = a[0]; end
            4'd9:  begin r = (a >> 1) | {c, 31'd0};          co = a[0]; end
            4'd10: begin r = a >> 1;                         co = a[0]; end
            default: r = 32'd0;
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic c);
        exp_t e;
        @(negedge clk_i);
        valid_i = 1'b1; op_i = op; ra_i = a; rb_i = b; carry_i = c;
        e.op = op;
        model(op, a, b, c, e.res, e.cry);
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk_i);
        valid_i = 1'b0;
        op_i = 4'd4; ra_i = $urandom; carry_i = ~carry_i;
    endtask

    // monitor: each valid output pops one expected item
    always @(negedge clk_i) begin
        if (rst_ni && valid_o) begin
            exp_t e;
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected valid_o: actual 1 expected 0");
            end else begin
                e = sb.pop_front();
                if (result_o !== e.res) begin
                    n_bad++;
                    $display("FAIL %s op %0d result: actual %h expected %h",
                             tag(e.op), e.op, result_o, e.res);
                end
                n_chk++;
                if (carry_o !== e.cry) begin
                    n_bad++;
                    $display("FAIL %s op %0d carry: actual %b expected %b",
                             (e.op >= 8 && e.op <= 10) ? "R9" : "R10",
                             e.op, carry_o, e.cry);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] hold_r;
        logic        hold_c;
        logic [31:0] edges [8];
        edges[0] = 32'h0000_0000; edges[1] = 32'hFFFF_FFFF;
        edges[2] = 32'h8000_0000; edges[3] = 32'h0000_0001;
        edges[4] = 32'h0000_0080; edges[5] = 32'h0000_8000;
        edges[6] = 32'h1234_5678; edges[7] = 32'h7FFF_FFFE;

        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        // R1 reset state
        n_chk++;
        if (valid_o !== 1'b0 || result_o !== '0 || carry_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %b/%h/%b expected 0/0/0",
                     valid_o, result_o, carry_o);
        end
        rst_ni = 1'b1;

        // R3 priority and position cases
        drive(4'd0, 32'hAABBCCDD, 32'hAABBCCDD, 1'b0);
        drive(4'd0, 32'h11BBCCDD, 32'h22BBCCDD, 1'b0);
        drive(4'd0, 32'h1122CC44, 32'h5566CC88, 1'b0);
        drive(4'd0, 32'h112233DD, 32'h556677DD, 1'b0);
        drive(4'd0, 32'h11223344, 32'h55667788, 1'b1);
        // R4
        drive(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
        drive(4'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b0);
        // R5 boundaries
        drive(4'd3, 32'h0, 32'h0, 1'b1);
        drive(4'd3, 32'h8000_0000, 32'h0, 1'b0);
        drive(4'd3, 32'h1, 32'h0, 1'b0);
        // R9 / R8 carry interplay
        drive(4'd9, 32'h0000_0003, 32'h0, 1'b1);
        drive(4'd8, 32'h8000_0000, 32'h0, 1'b1);
        drive(4'd10, 32'hFFFF_FFFF, 32'h0, 1'b0);
        // R10 unused codes
        drive(4'd11, 32'hFFFF_FFFF, 32'h0, 1'b1);
        drive(4'd15, 32'h1234_5678, 32'h0, 1'b0);

        // edge patterns across all codes
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                drive(4'(op), edges[i], edges[(i + 3) % 8], 1'(i));

        // random operands
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = ($urandom_range(0, 3) == 0) ? a ^ (32'hFF << (8 * $urandom_range(0, 3))) : $urandom;
            drive(4'($urandom_range(0, 15)), a, b, 1'($urandom));
        end

        // R2 idle cycles: valid drops, outputs hold
        idle();
        @(negedge clk_i);
        hold_r = result_o; hold_c = carry_o;
        valid_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            idle();
            n_chk++;
            if (valid_o !== 1'b0 || result_o !== hold_r || carry_o !== hold_c) begin
                n_bad++;
                $display("FAIL R2 idle: actual %b/%h/%b expected 0/%h/%b",
                         valid_o, result_o, carry_o, hold_r, hold_c);
            end
        end

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2 outstanding results: actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule